// File: doc/BRIEF.md
# Serial Link Connection Sequencer

This block brings a point-to-point serial link with token-based flow control from reset to the running state. It then supervises the link while it runs. It watches decoded-event strobes from the receiver: NULL seen, flow-control token seen, normal character seen, time-code seen, and receive error. It also watches a credit-error flag from the transmitter and two link controls, start and disable. From these it decides whether the transmitter is held in reset, whether the receiver is enabled, and which class of character the transmitter may send.

Six states form the sequence: error-reset, error-wait, ready, started, connecting and run. Two timed windows govern them, a short one and a long one. A single down-counter in clock cycles provides both. The counter is reloaded whenever the state changes, and its terminal counts come from a clock-frequency parameter. At the default of 10 MHz the short window is 64 cycles (6.4 us) and the long window is 128 cycles (12.8 us). Which received events count as faults depends on the current state. Any fault sends the link back to error-reset.

Top module: `link_conn_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in error-reset whatever the other inputs are. In error-reset, tx_rst=1, rx_en=0, tx_perm=0 and state_oh=6'b000001.
- R2: Error-reset lasts exactly the short window (64 cycles at default) after reset release or entry, and then moves to error-wait. All receiver events, credit errors and link controls are ignored while in error-reset.
- R3: Error-wait returns to error-reset on rx_err, got_fct, got_nchar or got_tc. It ignores got_null, and with no fault for the long window (128 cycles) it moves to ready.
- R4: Ready returns to error-reset on rx_err, got_fct, got_nchar or got_tc. It moves to started when link_start=1 and link_disable=0, and otherwise stays in ready indefinitely.
- R5: Started (tx_perm=1, NULL only) moves to connecting on got_null. It returns to error-reset on rx_err, got_fct, got_nchar or got_tc, or when the long window passes without a NULL. A NULL in the last cycle of the window still advances.
- R6: Connecting (tx_perm=2, NULL and FCT) moves to run on got_fct. It returns to error-reset on rx_err, got_nchar or got_tc, or when the long window passes. It ignores got_null, and an FCT in the last cycle of the window still advances.
- R7: Run (tx_perm=3, all classes) returns to error-reset on rx_err, tx_credit_err or link_disable. All other received events leave it in run.
- R8: When a fault and an advancing event arrive in the same cycle, the fault wins and the next state is error-reset.
- R9: state_oh is one-hot with bit 0 error-reset, 1 error-wait, 2 ready, 3 started, 4 connecting and 5 run. tx_rst=1 exactly in error-reset, error-wait and ready. rx_en=0 only in error-reset. tx_perm is 0 in the first three states. Outputs follow the state register from the cycle after each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_err | input | 1 | Receiver reported a line or parity fault this cycle |
| got_null | input | 1 | Receiver decoded a NULL this cycle |
| got_fct | input | 1 | Receiver decoded a flow-control token this cycle |
| got_nchar | input | 1 | Receiver decoded a normal character this cycle |
| got_tc | input | 1 | Receiver decoded a time-code this cycle |
| tx_credit_err | input | 1 | Transmitter credit counter fault |
| link_start | input | 1 | Request to bring the link up |
| link_disable | input | 1 | Request to take the link down |
| tx_rst | output | 1 | Hold the transmitter in reset |
| rx_en | output | 1 | Receiver enable |
| tx_perm | output | 2 | Permitted transmit class: 0 none, 1 NULL, 2 NULL+FCT, 3 all |
| state_oh | output | 6 | One-hot current state |

## Verification
The window expiry and the advancing token can fall in the same cycle. This happens when a NULL arrives in the last cycle of the started window, or an FCT in the last cycle of the connecting window. The bench provokes both by counting exactly 127 idle cycles after entry before it pulses the token, and it expects an advance rather than a fall to error-reset. The other collision is a fault arriving together with the advancing token, such as an FCT and a receive error in connecting. It is provoked directly, and the expected result is error-reset. Random stimulus weighted by state revisits both collisions against a cycle-by-cycle reference model.

// File: rtl/link_conn_pkg.sv
package link_conn_pkg;

    localparam int unsigned NUM_STATES = 6;

    typedef enum logic [2:0] {
        ST_ERST  = 3'd0,
        ST_EWAIT = 3'd1,
        ST_READY = 3'd2,
        ST_START = 3'd3,
        ST_CONN  = 3'd4,
        ST_RUN   = 3'd5
    } lc_state_e;

    typedef enum logic [1:0] {
        TXP_NONE     = 2'd0,
        TXP_NULL     = 2'd1,
        TXP_NULL_FCT = 2'd2,
        TXP_ALL      = 2'd3
    } tx_perm_e;

    typedef struct packed {
        logic err;
        logic nul;
        logic fct;
        logic nch;
        logic tc;
    } rx_ev_t;

    typedef struct packed {
        logic start;
        logic disable_req;
        logic credit_err;
    } ctl_t;

    // Convert a duration in nanoseconds to clock cycles, at least one.
    function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned dur_ns);
        longint unsigned c;
        c = (clk_hz * dur_ns) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

endpackage

// File: rtl/lc_timer.sv
module lc_timer
    import link_conn_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 64,
    parameter int unsigned LONG_CYC  = 128
) (
    input  logic clk,
    input  logic load,
    input  logic sel_short,
    output logic expired
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] RL_SHORT = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] RL_LONG  = CW'(LONG_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load) begin
            cnt_q <= sel_short ? RL_SHORT : RL_LONG;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lc_next_state.sv
module lc_next_state
    import link_conn_pkg::*;
(
    input  lc_state_e st,
    input  rx_ev_t    ev,
    input  ctl_t      ctl,
    input  logic      expired,
    output lc_state_e nxt
);
    logic fault_idle;   // faults while waiting or starting
    logic fault_conn;   // faults while connecting

    assign fault_idle = ev.err | ev.fct | ev.nch | ev.tc;
    assign fault_conn = ev.err | ev.nch | ev.tc;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_ERST: begin
                if (expired) nxt = ST_EWAIT;
            end
            ST_EWAIT: begin
                if (fault_idle)   nxt = ST_ERST;
                else if (expired) nxt = ST_READY;
            end
            ST_READY: begin
                if (fault_idle)                          nxt = ST_ERST;
                else if (ctl.start && !ctl.disable_req)  nxt = ST_START;
            end
            ST_START: begin
                if (fault_idle)   nxt = ST_ERST;
                else if (ev.nul)  nxt = ST_CONN;
                else if (expired) nxt = ST_ERST;
            end
            ST_CONN: begin
                if (fault_conn)   nxt = ST_ERST;
                else if (ev.fct)  nxt = ST_RUN;
                else if (expired) nxt = ST_ERST;
            end
            ST_RUN: begin
                if (ev.err || ctl.credit_err || ctl.disable_req) nxt = ST_ERST;
            end
            default: nxt = ST_ERST;
        endcase
    end

endmodule

// File: rtl/lc_out_decode.sv
module lc_out_decode
    import link_conn_pkg::*;
(
    input  lc_state_e             st,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  tx_rst,
    output logic                  rx_en,
    output logic [1:0]            tx_perm
);
    for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
        assign state_oh[i] = (st == lc_state_e'(3'(i)));
    end

    tx_perm_e perm;

    always_comb begin
        unique case (st)
            ST_START: perm = TXP_NULL;
            ST_CONN:  perm = TXP_NULL_FCT;
            ST_RUN:   perm = TXP_ALL;
            default:  perm = TXP_NONE;
        endcase
    end

    assign tx_perm = perm;
    assign tx_rst  = (st == ST_ERST) || (st == ST_EWAIT) || (st == ST_READY);
    assign rx_en   = (st != ST_ERST);

endmodule

// File: rtl/link_conn_ctrl.sv
module link_conn_ctrl
    import link_conn_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 10_000_000,
    parameter int unsigned SHORT_NS = 6400,
    parameter int unsigned LONG_NS  = 12800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_err,
    input  logic       got_null,
    input  logic       got_fct,
    input  logic       got_nchar,
    input  logic       got_tc,
    input  logic       tx_credit_err,
    input  logic       link_start,
    input  logic       link_disable,
    output logic       tx_rst,
    output logic       rx_en,
    output logic [1:0] tx_perm,
    output logic [5:0] state_oh
);
    localparam int unsigned SHORT_CYC = ns_to_cycles(64'(CLK_HZ), 64'(SHORT_NS));
    localparam int unsigned LONG_CYC  = ns_to_cycles(64'(CLK_HZ), 64'(LONG_NS));

    lc_state_e st_q;
    lc_state_e nxt;
    rx_ev_t    ev;
    ctl_t      ctl;
    logic      expired;
    logic      load;
    logic      sel_short;

    assign ev  = '{err: rx_err, nul: got_null, fct: got_fct, nch: got_nchar, tc: got_tc};
    assign ctl = '{start: link_start, disable_req: link_disable, credit_err: tx_credit_err};

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_ERST;
        else     st_q <= nxt;
    end

    // Reload the window on reset and on every change of state.
    assign load      = rst || (nxt != st_q);
    assign sel_short = rst || (nxt == ST_ERST);

    lc_timer #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .load     (load),
        .sel_short(sel_short),
        .expired  (expired)
    );

    lc_next_state u_next (
        .st     (st_q),
        .ev     (ev),
        .ctl    (ctl),
        .expired(expired),
        .nxt    (nxt)
    );

    lc_out_decode u_dec (
        .st      (st_q),
        .state_oh(state_oh),
        .tx_rst  (tx_rst),
        .rx_en   (rx_en),
        .tx_perm (tx_perm)
    );

endmodule

// File: rtl/link_conn_chk.sv
module link_conn_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_err,
    input logic       got_null,
    input logic       got_fct,
    input logic       got_nchar,
    input logic       got_tc,
    input logic       tx_credit_err,
    input logic       link_start,
    input logic       link_disable,
    input logic       tx_rst,
    input logic       rx_en,
    input logic [1:0] tx_perm,
    input logic [5:0] state_oh
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state_oh == 6'b000001 && tx_rst && !rx_en && tx_perm == 2'd0));

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    a_r9_tx_reset_states: assert property (@(posedge clk) disable iff (rst)
        tx_rst == (state_oh[0] | state_oh[1] | state_oh[2]));

    a_r2_erst_exit_only_wait: assert property (@(posedge clk) disable iff (rst)
        state_oh[0] |=> (state_oh[0] || state_oh[1]));

    a_r3_wait_fault: assert property (@(posedge clk) disable iff (rst)
        (state_oh[1] && (rx_err || got_fct || got_nchar || got_tc)) |=> state_oh[0]);

    a_r5_started_perm: assert property (@(posedge clk) disable iff (rst)
        state_oh[3] |-> (tx_perm == 2'd1));

    a_r6_conn_advance: assert property (@(posedge clk) disable iff (rst)
        (state_oh[4] && got_fct && !rx_err && !got_nchar && !got_tc) |=> state_oh[5]);

    a_r7_run_exit: assert property (@(posedge clk) disable iff (rst)
        (state_oh[5] && (rx_err || tx_credit_err || link_disable)) |=> state_oh[0]);

    a_r8_fault_wins: assert property (@(posedge clk) disable iff (rst)
        ((state_oh[3] || state_oh[4]) && rx_err) |=> state_oh[0]);

endmodule

bind link_conn_ctrl link_conn_chk u_chk (.*);

// File: tb/link_conn_ctrl_test.sv
`timescale 1ns/1ps
module link_conn_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] v   = 8'd0;   // [0]err [1]null [2]fct [3]nchar [4]tc [5]credit [6]start [7]disable
    logic       tx_rst, rx_en;
    logic [1:0] tx_perm;
    logic [5:0] state_oh;

    localparam logic [7:0] E_ERR = 8'h01, E_NUL = 8'h02, E_FCT = 8'h04, E_NCH = 8'h08,
                           E_TC  = 8'h10, E_CR  = 8'h20, E_STA = 8'h40, E_DIS = 8'h80;
    localparam int SHORT = 64;
    localparam int LONG  = 128;

    int checks   = 0;
    int failures = 0;
    int m_st     = 0;
    int m_age    = 0;
    int cycles   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    link_conn_ctrl uut (
        .clk(clk), .rst(rst),
        .rx_err(v[0]), .got_null(v[1]), .got_fct(v[2]), .got_nchar(v[3]), .got_tc(v[4]),
        .tx_credit_err(v[5]), .link_start(v[6]), .link_disable(v[7]),
        .tx_rst(tx_rst), .rx_en(rx_en), .tx_perm(tx_perm), .state_oh(state_oh)
    );

    function automatic int ref_next(int s, int age, logic [7:0] i);
        logic flt;
        flt = i[0] | i[2] | i[3] | i[4];
        case (s)
            0: return (age >= SHORT - 1) ? 1 : 0;
            1: return flt ? 0 : ((age >= LONG - 1) ? 2 : 1);
            2: return flt ? 0 : ((i[6] && !i[7]) ? 3 : 2);
            3: return flt ? 0 : (i[1] ? 4 : ((age >= LONG - 1) ? 0 : 3));
            4: return (i[0] | i[3] | i[4]) ? 0 : (i[2] ? 5 : ((age >= LONG - 1) ? 0 : 4));
            default: return (i[0] | i[5] | i[7]) ? 0 : 5;
        endcase
    endfunction

    function automatic logic [1:0] ref_perm(int s);
        return (s <= 2) ? 2'd0 : 2'(s - 2);
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R2"; 1: return "R3"; 2: return "R4";
            3: return "R5"; 4: return "R6"; default: return "R7";
        endcase
    endfunction

    task automatic compare_all(string tag);
        logic [9:0] act, exp;
        act = {state_oh, tx_rst, rx_en, tx_perm};
        exp = {6'(1 << m_st), (m_st <= 2), (m_st != 0), ref_perm(m_st)};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s R9 outputs act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_st(int exp, string tag);
        checks++;
        if (state_oh !== 6'(1 << exp)) begin
            failures++;
            $display("FAIL %s state act=%b exp=%b", tag, state_oh, 6'(1 << exp));
        end
    endtask

    // One cycle: inputs set after a falling edge, model steps at the rising edge,
    // outputs compared at the next falling edge.
    task automatic cyc(logic [7:0] inp, logic r);
        string t;
        v = inp; rst = r;
        t = r ? "R1" : tag_of(m_st);
        @(posedge clk);
        if (r) begin
            m_st = 0; m_age = 0;
        end else begin
            int n;
            n = ref_next(m_st, m_age, inp);
            m_age = (n != m_st) ? 0 : m_age + 1;
            m_st = n;
        end
        @(negedge clk);
        compare_all(t);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(8'd0, 1'b0);
    endtask

    task automatic goto_ready();
        cyc(8'd0, 1'b1);
        idle(SHORT + LONG);
    endtask

    task automatic goto_started();
        goto_ready();
        cyc(E_STA, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(E_STA | E_NUL | E_FCT, 1'b1);
        chk_st(0, "R1 reset state");

        // R2: error-reset ignores everything for the short window
        for (int k = 0; k < SHORT - 1; k++) cyc(8'hFF, 1'b0);
        chk_st(0, "R2 still error-reset");
        cyc(8'hFF & ~E_ERR, 1'b0);
        chk_st(1, "R2 error-wait after window");

        // R3: NULL ignored in error-wait, then ready after the long window
        for (int k = 0; k < LONG - 1; k++) cyc(E_NUL, 1'b0);
        chk_st(1, "R3 still error-wait");
        cyc(8'd0, 1'b0);
        chk_st(2, "R3 ready after window");

        // R4: disable overrides start; time-code is a fault
        idle(300);
        chk_st(2, "R4 ready holds");
        cyc(E_STA | E_DIS, 1'b0);
        chk_st(2, "R4 disable blocks start");
        cyc(E_TC, 1'b0);
        chk_st(0, "R4 time-code fault");

        // R5: timeout without NULL
        goto_started();
        chk_st(3, "R5 started");
        idle(LONG - 1);
        chk_st(3, "R5 last window cycle");
        cyc(8'd0, 1'b0);
        chk_st(0, "R5 timeout");

        // R5: NULL on the last window cycle advances
        goto_started();
        idle(LONG - 1);
        cyc(E_NUL, 1'b0);
        chk_st(4, "R5 late NULL advances");

        // R6/R8: NULL ignored, FCT with receive error falls back
        cyc(E_NUL, 1'b0);
        chk_st(4, "R6 NULL ignored");
        cyc(E_FCT | E_ERR, 1'b0);
        chk_st(0, "R8 fault beats FCT");

        // R6: FCT on the last window cycle advances
        goto_started();
        cyc(E_NUL, 1'b0);
        idle(LONG - 1);
        cyc(E_FCT, 1'b0);
        chk_st(5, "R6 late FCT advances");

        // R7: run tolerates tokens and data, leaves on credit error
        for (int k = 0; k < 20; k++) cyc(E_NUL | E_FCT | E_NCH | E_TC | E_STA, 1'b0);
        chk_st(5, "R7 run holds");
        cyc(E_CR, 1'b0);
        chk_st(0, "R7 credit error");

        // R1: reset overrides a running link
        goto_started();
        cyc(E_NUL, 1'b0);
        cyc(E_FCT, 1'b0);
        cyc(E_FCT | E_NUL, 1'b1);
        chk_st(0, "R1 reset from run");

        // Random phase, weighted by model state
        begin
            int seed;
            int dummy;
            seed = 32'h5EED_1234;
            dummy = $urandom(seed);
            for (int k = 0; k < 20000; k++) begin
                logic [7:0] x;
                int rare;
                rare = (m_st == 1 || m_st == 2) ? 400 : 60;
                x = 8'd0;
                x[0] = ($urandom % rare) == 0;
                x[1] = ($urandom % ((m_st == 3) ? 30 : 6)) == 0;
                x[2] = ($urandom % ((m_st == 4) ? 30 : rare)) == 0;
                x[3] = ($urandom % ((m_st == 5) ? 4 : rare)) == 0;
                x[4] = ($urandom % ((m_st == 5) ? 8 : rare)) == 0;
                x[5] = ($urandom % 150) == 0;
                x[6] = ($urandom % 4) != 0;
                x[7] = ($urandom % 120) == 0;
                cyc(x, ($urandom % 3000) == 0);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule